// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit write bus with combinational read-back. It counts a slow time-base strobe (`tick_i`, nominally a 32 kHz tick). Software sets a timeout in units of `UNIT_TICKS` ticks and must refresh the timer before the timeout runs out. When it does not, the block raises a system reset pulse.

In two-stage mode, the first expiry does not reset the system. It marks an interrupt as pending and starts a second period of the same length. Only a second expiry with no refresh produces the reset. The reset pulse can also drive an external pin, whose active level is programmable.

Each of the four registers accepts a write only when the written word carries that register's own key. A write without the key changes nothing. This guards the block against stray stores.

Top module: `keyed_wdog`

## Requirements
- R1: Control register at address 0x00. A write takes effect only when data[31:24] equals 0x22; any other write leaves the register unchanged. Stored fields: bit0 run, bit1 external level (1 = pin active high), bit2 external pin enable, bit3 interrupt enable, bit4 auto re-arm, bit6 two-stage. Read-back shows these bits, with all other bits zero.
- R2: Period register at address 0x04. A write takes effect only when data[4:0] equals 0x08. The period count is data[15:5]. Read-back returns the count in bits [15:5], with bits [4:0] zero.
- R3: In one-stage mode, a reset pulse starts when `len*UNIT_TICKS` ticks have been counted since the timer was loaded. The pulse appears in the cycle after the edge that counts the last tick.
- R4: Writing exactly 0x00001971 to address 0x08 reloads the timer. Any other value has no effect. Address 0x08 reads as zero.
- R5: Writing exactly 0x00001209 to address 0x14 starts a reset pulse on the same edge. Any other value starts none. Address 0x14 reads as zero.
- R6: In two-stage mode, the first expiry sets the pending interrupt and reloads the timer; `irq_o` shows it when bit3 is set. A second expiry without a reload starts the reset pulse.
- R7: A valid reload clears the pending interrupt and returns the timer to its first stage.
- R8: While the run bit is clear, the timer holds its value and no expiry occurs. A write that sets the run bit from clear loads the timer.
- R9: The reset pulse lasts `PULSE_LEN` cycles. It clears the run bit, unless auto re-arm is set; in that case the timer restarts from a full load.
- R10: `ext_rst_o` carries the reset pulse at the selected level when bit2 is set. At all other times it sits at the inactive level of bit1.
- R11: The timer advances only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one cycle per tick |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data including key |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | First-stage expiry interrupt |
| sys_rst_o | output | 1 | System reset pulse, active high |
| ext_rst_o | output | 1 | External reset pin, programmable level |

## Verification
A write takes effect on the rising edge that samples it. Read data is combinational, so it is sampled half a cycle after that edge. A software reset shows on `sys_rst_o` in the cycle after the write edge.

A timer load on edge E0 gives an expiry on edge E0 + len*UNIT_TICKS when `tick_i` is always high. The interrupt or pulse is registered on that edge. The bench counts falling edges from the write and checks the output one cycle before the due edge (expecting low) and on the due edge (expecting high).

The pulse width is checked at its last high cycle and its first low cycle. With an alternating tick, the pulse is accepted within a two-cycle window, because the phase of the strobe is not fixed.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_PERIOD  = 5'h04;
  localparam logic [ADDR_W-1:0] A_RELOAD  = 5'h08;
  localparam logic [ADDR_W-1:0] A_SWRESET = 5'h14;

  localparam logic [7:0]        K_CTRL    = 8'h22;
  localparam logic [4:0]        K_PERIOD  = 5'h08;
  localparam logic [DATA_W-1:0] K_RELOAD  = 32'h0000_1971;
  localparam logic [DATA_W-1:0] K_SWRESET = 32'h0000_1209;

  typedef struct packed {
    logic two_stage;
    logic rearm;
    logic irq_en;
    logic pin_en;
    logic pin_high;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
  import keyed_wdog_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fire_i,
  output ctrl_t             ctrl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              load_o,
  output logic              swreset_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             ctrl_wr, len_wr, reload_ok;

  always_comb begin
    ctrl_wr   = wr_i && addr_i == A_CTRL && wdata_i[31:24] == K_CTRL;
    len_wr    = wr_i && addr_i == A_PERIOD && wdata_i[4:0] == K_PERIOD;
    reload_ok = wr_i && addr_i == A_RELOAD && wdata_i == K_RELOAD;
    swreset_o = wr_i && addr_i == A_SWRESET && wdata_i == K_SWRESET;

    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.run       = wdata_i[0];
      ctrl_d.pin_high  = wdata_i[1];
      ctrl_d.pin_en    = wdata_i[2];
      ctrl_d.irq_en    = wdata_i[3];
      ctrl_d.rearm     = wdata_i[4];
      ctrl_d.two_stage = wdata_i[6];
    end
    if (fire_i) ctrl_d.run = ctrl_d.rearm;

    len_d  = len_wr ? wdata_i[5 +: LEN_W] : len_q;
    load_o = reload_ok || (ctrl_wr && wdata_i[0] && !ctrl_q.run);

    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o[6:0] = {ctrl_q.two_stage, 1'b0, ctrl_q.rearm, ctrl_q.irq_en,
                                ctrl_q.pin_en, ctrl_q.pin_high, ctrl_q.run};
      A_PERIOD: rdata_o[5 +: LEN_W] = len_q;
      default:  rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      len_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      len_q  <= len_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign len_o  = len_q;

  // R1: a control write without its key leaves the register as it was
  p_keyless_ctrl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_CTRL && wdata_i[31:24] != K_CTRL && !fire_i) |=> $stable(ctrl_q));
  // R2: a period write without its key leaves the register as it was
  p_keyless_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_PERIOD && wdata_i[4:0] != K_PERIOD) |=> $stable(len_q));
endmodule

// File: rtl/keyed_wdog_timer.sv
module keyed_wdog_timer #(
  parameter int LEN_W      = 11,
  parameter int UNIT_TICKS = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             two_stage_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             load_i,
  input  logic             fire_i,
  output logic             bite_o,
  output logic             pend_o
);
  localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             stage_q, stage_d, pend_q, pend_d;
  logic             step, wrap, expire;

  always_comb begin
    step   = run_i && tick_i;
    wrap   = step && pre_q == PRE_LAST;
    expire = wrap && cnt_q <= LEN_W'(1);
    bite_o = expire && (stage_q || !two_stage_i);

    pre_d = pre_q; cnt_d = cnt_q; stage_d = stage_q; pend_d = pend_q;
    if (load_i || fire_i) begin
      pre_d = '0; cnt_d = len_i; stage_d = 1'b0; pend_d = 1'b0;
    end else if (expire) begin
      pre_d = '0; cnt_d = len_i; stage_d = 1'b1; pend_d = 1'b1;
    end else if (wrap) begin
      pre_d = '0; cnt_d = cnt_q - LEN_W'(1);
    end else if (step) begin
      pre_d = pre_q + PRE_W'(1);
    end
    if (!two_stage_i) begin
      stage_d = 1'b0; pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0; cnt_q <= '0; stage_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      pre_q <= pre_d; cnt_q <= cnt_d; stage_q <= stage_d; pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R8: a stopped timer holds its count
  p_hold_when_stopped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i && !fire_i) |=> ($stable(cnt_q) && $stable(pre_q)));
  // R7: a reload returns to stage one with nothing pending
  p_reload_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!pend_q && !stage_q));
  // R11: without a tick the prescaler does not move
  p_no_tick_no_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !fire_i) |=> $stable(pre_q));
endmodule

// File: rtl/keyed_wdog_pulse.sv
module keyed_wdog_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic pin_en_i,
  input  logic pin_high_i,
  output logic pulse_o,
  output logic pin_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (fire_i)              left_d = PW'(PULSE_LEN);
    else if (left_q != '0)   left_d = left_q - PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else         left_q <= left_d;
  end

  assign pulse_o = left_q != '0;
  assign pin_o   = (pulse_o && pin_en_i) ? pin_high_i : !pin_high_i;

  // R5: a fire request is visible on the pulse in the next cycle
  p_fire_starts_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> pulse_o);
  // R9: the pulse is never a single cycle wide
  p_pulse_not_glitch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |=> pulse_o);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int LEN_W      = 11,
  parameter int UNIT_TICKS = 512,
  parameter int PULSE_LEN  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o,
  output logic              ext_rst_o
);
  logic [1:0]       sync_q;
  logic             rst_n;
  ctrl_t            ctrl;
  logic [LEN_W-1:0] len;
  logic             load, swreset, bite, fire, pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n = sync_q[1];

  assign fire = bite || swreset;

  keyed_wdog_regs #(.LEN_W(LEN_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .fire_i(fire), .ctrl_o(ctrl), .len_o(len),
    .rdata_o(bus_rdata_o), .load_o(load), .swreset_o(swreset)
  );

  keyed_wdog_timer #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT_TICKS)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(ctrl.run), .tick_i(tick_i),
    .two_stage_i(ctrl.two_stage), .len_i(len), .load_i(load), .fire_i(fire),
    .bite_o(bite), .pend_o(pend)
  );

  keyed_wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_n), .fire_i(fire), .pin_en_i(ctrl.pin_en),
    .pin_high_i(ctrl.pin_high), .pulse_o(sys_rst_o), .pin_o(ext_rst_o)
  );

  assign irq_o = pend && ctrl.irq_en;
endmodule

// File: tb/keyed_wdog_test.sv
module keyed_wdog_test;
  localparam int UNIT = 4;
  localparam int PLEN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        tick_alt = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, srst, pin;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  keyed_wdog #(.LEN_W(11), .UNIT_TICKS(UNIT), .PULSE_LEN(PLEN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .sys_rst_o(srst),
    .ext_rst_o(pin)
  );

  always #10 clk = ~clk;
  always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

  // {addr, write data, expected read-back at the same address}
  localparam logic [68:0] VEC [0:9] = '{
    {5'h00, 32'h2200_007E, 32'h0000_005E},
    {5'h00, 32'h2100_001F, 32'h0000_005E},
    {5'h00, 32'h2200_0000, 32'h0000_0000},
    {5'h04, 32'h0000_0068, 32'h0000_0060},
    {5'h04, 32'h0000_0069, 32'h0000_0060},
    {5'h04, 32'h0000_FFE8, 32'h0000_FFE0},
    {5'h04, 32'h0000_0047, 32'h0000_FFE0},
    {5'h04, 32'h0000_0048, 32'h0000_0040},
    {5'h08, 32'h0000_1971, 32'h0000_0000},
    {5'h14, 32'h0000_1208, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // called just after a falling edge; the write lands on the next rising edge
  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    read_chk("R1 reset", 5'h00, 32'h0);
    read_chk("R2 reset", 5'h04, 32'h0);
    chk("R9 reset pulse", {31'b0, srst}, 32'h0);
    chk("R6 reset irq", {31'b0, irq}, 32'h0);
    chk("R10 reset pin idles high", {31'b0, pin}, 32'h1);

    // key-checking table
    for (int i = 0; i < 10; i++) begin
      logic [4:0] a;
      a = VEC[i][68:64];
      bus_write(a, VEC[i][63:32]);
      case (a)
        5'h00:   read_chk("R1 ctrl key", a, VEC[i][31:0]);
        5'h04:   read_chk("R2 period key", a, VEC[i][31:0]);
        5'h08:   read_chk("R4 reload reads 0", a, VEC[i][31:0]);
        default: read_chk("R5 swreset reads 0", a, VEC[i][31:0]);
      endcase
    end
    chk("R5 bad swreset key no pulse", {31'b0, srst}, 32'h0);

    // R3: one-stage expiry, period 3 -> 12 ticks
    bus_write(5'h04, 32'h0000_0068);
    bus_write(5'h00, 32'h2200_0001);
    wait_n(11); chk("R3 not yet expired", {31'b0, srst}, 32'h0);
    wait_n(1);  chk("R3 expiry pulse", {31'b0, srst}, 32'h1);
    wait_n(3);  chk("R9 pulse still high", {31'b0, srst}, 32'h1);
    wait_n(1);  chk("R9 pulse ended", {31'b0, srst}, 32'h0);
    read_chk("R9 run cleared", 5'h00, 32'h0);

    // R4: valid reload postpones, invalid does not; period 2 -> 8 ticks
    bus_write(5'h04, 32'h0000_0048);
    bus_write(5'h00, 32'h2200_0001);
    wait_n(5); bus_write(5'h08, 32'h0000_1971);
    wait_n(7); chk("R4 reload postpones", {31'b0, srst}, 32'h0);
    wait_n(1); chk("R4 expiry after reload", {31'b0, srst}, 32'h1);
    wait_n(6);
    bus_write(5'h00, 32'h2200_0001);
    wait_n(4); bus_write(5'h08, 32'h0000_1970);
    wait_n(2); chk("R4 bad key no reload (before)", {31'b0, srst}, 32'h0);
    wait_n(1); chk("R4 bad key no reload", {31'b0, srst}, 32'h1);
    wait_n(6);

    // R6/R7: two stages with interrupt
    bus_write(5'h00, 32'h2200_0049);
    wait_n(7); chk("R6 no early bark", {31'b0, irq}, 32'h0);
    wait_n(1); chk("R6 bark", {31'b0, irq}, 32'h1);
    chk("R6 no reset at first expiry", {31'b0, srst}, 32'h0);
    wait_n(1); bus_write(5'h08, 32'h0000_1971);
    chk("R7 reload clears bark", {31'b0, irq}, 32'h0);
    wait_n(7); chk("R7 back in stage one", {31'b0, irq}, 32'h0);
    wait_n(1); chk("R7 bark again", {31'b0, irq}, 32'h1);
    chk("R7 stage one no reset", {31'b0, srst}, 32'h0);
    wait_n(7); chk("R6 bite not yet", {31'b0, srst}, 32'h0);
    wait_n(1); chk("R6 bite", {31'b0, srst}, 32'h1);
    chk("R6 bite clears bark", {31'b0, irq}, 32'h0);
    wait_n(6);

    // R8: stopped timer never expires
    bus_write(5'h00, 32'h2200_0001);
    wait_n(3); bus_write(5'h00, 32'h2200_0000);
    wait_n(20); chk("R8 stopped no expiry", {31'b0, srst}, 32'h0);
    bus_write(5'h00, 32'h2200_0001);
    wait_n(7); chk("R8 re-run loads full period", {31'b0, srst}, 32'h0);
    wait_n(1); chk("R8 expiry after re-run", {31'b0, srst}, 32'h1);
    wait_n(6);

    // R5/R9: software reset, with and without re-arm
    bus_write(5'h00, 32'h2200_0011);
    bus_write(5'h14, 32'h0000_1209);
    chk("R5 swreset pulse", {31'b0, srst}, 32'h1);
    read_chk("R9 rearm keeps run", 5'h00, 32'h11);
    wait_n(7); chk("R9 rearm restarted timer", {31'b0, srst}, 32'h0);
    wait_n(1); chk("R9 rearm expiry", {31'b0, srst}, 32'h1);
    bus_write(5'h00, 32'h2200_0000);
    wait_n(6);

    // R10: pin levels
    bus_write(5'h00, 32'h2200_0007);
    wait_n(7); chk("R10 high-active idle", {31'b0, pin}, 32'h0);
    wait_n(1); chk("R10 high-active pulse", {31'b0, pin}, 32'h1);
    wait_n(6);
    bus_write(5'h00, 32'h2200_0005);
    wait_n(7); chk("R10 low-active idle", {31'b0, pin}, 32'h1);
    wait_n(1); chk("R10 low-active pulse", {31'b0, pin}, 32'h0);
    wait_n(6);
    bus_write(5'h00, 32'h2200_0001);
    wait_n(8); chk("R10 pin disabled idle", {31'b0, pin}, 32'h1);
    wait_n(6);

    // R11: tick every other cycle doubles the time
    tick_alt = 1'b1;
    bus_write(5'h00, 32'h2200_0001);
    begin
      int n;
      n = 0;
      while (!srst && n < 40) begin
        @(negedge clk); n++;
      end
      chk("R11 half-rate tick window", {31'b0, (n >= 15 && n <= 16)}, 32'h1);
    end
    tick_alt = 1'b0;
    wait_n(6);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end
endmodule